// File: doc/BRIEF.md
# Multi-Hart Debug Controller with Availability Gating

This block is the run-control part of a debug controller for a small cluster of harts. A debugger reaches it through a single-cycle register port. The port has a strobe, a write enable, an address and write data, and read data returns in the cycle after the strobe. Through this port the debugger selects one hart and asks it to halt, resume or reset. It also reads a combined status word for the selected hart and places harts into halt groups. Each hart reports back a level that says whether it is halted.

A register written by software holds one availability bit for each of the lowest-numbered harts. When a hart is marked unavailable, the block does not send it halt, resume or reset actions. It also leaves that hart out when a halt in one hart spreads to the others in its group. The status word reports the hart as unavailable instead of running. Harts whose index lies above the range of the availability register always count as available. Halt requests are levels that stay set. A separate output bit marks a request that came from a group halt rather than from the debugger.

Top module: `dbg_avail_ctrl`

## Requirements
- R1: The availability register sits at address 0x1F. Bit 0 is hart 0 and bit 1 is hart 1, and 1 means available. It resets to 0b11. A write loads bits [1:0] and ignores the higher bits. A read returns the two bits at [1:0] with zeros above.
- R2: A hart whose index is 2 or more always counts as available, whatever is written to the availability register.
- R3: A read of address 0x11 returns the status word, computed over the selected hart only. The bits are: [0] anyhalted, [1] allhalted, [2] anyrunning, [3] allrunning, [4] anyunavail, [5] allunavail, [6] anynonexistent, [7] allnonexistent, [8] anyresumeack, [9] allresumeack, [10] havereset of the selected hart. A halted hart reads 0x03 in bits [7:0], whether it is available or not. A hart that is not halted and is unavailable reads 0x30. A hart that is available and running reads 0x0C.
- R4: When the hart select value is at least NUM_HARTS (default 4), bits [7:0] read 0xEA. This means every all-flag is 1, every any-flag is 0, and anynonexistent is 1.
- R5: A write to address 0x10 (control) loads the hart select from bits [19:16] and acts on the hart it names. Bit 31 is haltreq. The hart's halt_req_o becomes 1 (with halt_grp_o 0) only when haltreq is 1 and the hart is available. In every other case the request is cleared. The request is a level that holds until the next control write to that hart.
- R6: Control bit 30 (resumereq) gives a one-cycle resume_o pulse and clears the hart's resumeack, but only when the hart is available. resumeack becomes 1 when the hart's halted input falls.
- R7: Control bit 29 (hartreset) gives a one-cycle hart_reset_o pulse and sets havereset, but only when the hart is available. Control bit 28 (ackhavereset) clears havereset whether the hart is available or not. havereset is 1 after reset.
- R8: Address 0x32 reads and writes bits [4:0] as the halt group of the selected hart. Group 0 means no group. Groups reset to 0.
- R9: When a hart's halted input rises and its group is not zero, every other hart in the same group that is not halted and is available gets a request with halt_req_o and halt_grp_o both set, in the next cycle.
- R10: When a group request and a control write target the same hart in the same cycle, the control write decides that hart's halt request.
- R11: A read strobe gives reg_rvalid_o and reg_rdata_o in the following cycle. An unmapped address reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_req_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 7 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvalid_o |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a read strobe |
| hart_halted_i | input | NUM_HARTS | Per-hart halted level |
| halt_req_o | output | NUM_HARTS | Per-hart halt request level |
| halt_grp_o | output | NUM_HARTS | Set when the pending halt request came from a group halt |
| resume_o | output | NUM_HARTS | Per-hart resume pulse |
| hart_reset_o | output | NUM_HARTS | Per-hart reset pulse |

## Verification
A group halt caused by a halted edge on one hart can fall in the same clock edge as a debugger control write to another member of that group. The bench provokes this by raising hart 0's halted input in the same cycle that it drives a control write with haltreq clear. In one run the write targets hart 2, a member of the group. In the other run it targets hart 3, which is outside the group. With hart 2 as the target, the write must win and leave hart 2 with no request. With hart 3 as the target, hart 2 must still get the group request.

// File: rtl/dbg_avail_pkg.sv
package dbg_avail_pkg;

  typedef enum logic [1:0] {
    HK_NONE    = 2'd0,
    HK_REGULAR = 2'd1,
    HK_GROUP   = 2'd2
  } halt_kind_e;

  localparam logic [6:0] ADDR_CTRL  = 7'h10;
  localparam logic [6:0] ADDR_STAT  = 7'h11;
  localparam logic [6:0] ADDR_AVAIL = 7'h1F;
  localparam logic [6:0] ADDR_GROUP = 7'h32;

  localparam int CTL_HALT_BIT   = 31;
  localparam int CTL_RESUME_BIT = 30;
  localparam int CTL_HRESET_BIT = 29;
  localparam int CTL_ACKHR_BIT  = 28;
  localparam int CTL_SEL_LSB    = 16;

  typedef struct packed {
    logic havereset;
    logic allresumeack;
    logic anyresumeack;
    logic allnonexist;
    logic anynonexist;
    logic allunavail;
    logic anyunavail;
    logic allrunning;
    logic anyrunning;
    logic allhalted;
    logic anyhalted;
  } status_t;

  localparam int STATUS_W = $bits(status_t);

endpackage

// File: rtl/dbg_hart_slot.sv
module dbg_hart_slot
  import dbg_avail_pkg::*;
#(
  parameter int GROUP_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_wr_i,
  input  logic               haltreq_i,
  input  logic               resumereq_i,
  input  logic               hartreset_i,
  input  logic               ackhr_i,
  input  logic               grp_wr_i,
  input  logic [GROUP_W-1:0] grp_wdata_i,
  input  logic               avail_i,
  input  logic               halted_i,
  input  logic               grp_halt_i,
  output logic               halted_rise_o,
  output logic [GROUP_W-1:0] group_o,
  output logic               resumeack_o,
  output logic               havereset_o,
  output logic               halt_req_o,
  output logic               halt_grp_o,
  output logic               resume_o,
  output logic               reset_o
);

  halt_kind_e         kind_q, kind_d;
  logic               kind_en;
  logic [GROUP_W-1:0] group_q;
  logic               halted_q;
  logic               resumeack_q, resumeack_d;
  logic               havereset_q, havereset_d;
  logic               resume_q, resume_d;
  logic               reset_q, reset_d;
  logic               halted_fall;

  assign halted_rise_o = halted_i & ~halted_q;
  assign halted_fall   = ~halted_i & halted_q;

  always_comb begin
    kind_en = grp_halt_i | ctl_wr_i;
    kind_d  = kind_q;
    if (grp_halt_i) kind_d = HK_GROUP;
    // a register write to this hart overrides a same-cycle group request
    if (ctl_wr_i) kind_d = (haltreq_i && avail_i) ? HK_REGULAR : HK_NONE;
  end

  always_comb begin
    resume_d = ctl_wr_i & resumereq_i & avail_i;
    reset_d  = ctl_wr_i & hartreset_i & avail_i;
    if (resume_d)         resumeack_d = 1'b0;
    else if (halted_fall) resumeack_d = 1'b1;
    else                  resumeack_d = resumeack_q;
    if (reset_d)                   havereset_d = 1'b1;
    else if (ctl_wr_i && ackhr_i)  havereset_d = 1'b0;
    else                           havereset_d = havereset_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q      <= HK_NONE;
      group_q     <= '0;
      halted_q    <= 1'b0;
      resumeack_q <= 1'b0;
      havereset_q <= 1'b1;
      resume_q    <= 1'b0;
      reset_q     <= 1'b0;
    end else begin
      if (kind_en)  kind_q  <= kind_d;
      if (grp_wr_i) group_q <= grp_wdata_i;
      halted_q    <= halted_i;
      resumeack_q <= resumeack_d;
      havereset_q <= havereset_d;
      resume_q    <= resume_d;
      reset_q     <= reset_d;
    end
  end

  assign group_o     = group_q;
  assign resumeack_o = resumeack_q;
  assign havereset_o = havereset_q;
  assign halt_req_o  = (kind_q != HK_NONE);
  assign halt_grp_o  = (kind_q == HK_GROUP);
  assign resume_o    = resume_q;
  assign reset_o     = reset_q;

  // R6
  resume_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_o |-> $past(avail_i && ctl_wr_i && resumereq_i));

  // R7
  reset_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o |-> havereset_o);

  // R5
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(halt_req_o) && !halt_grp_o) |-> $past(avail_i && haltreq_i && ctl_wr_i));

  // R9
  grp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_grp_o) |-> $past(avail_i && !halted_i));

endmodule

// File: rtl/dbg_group_fanout.sv
module dbg_group_fanout #(
  parameter int NUM_HARTS = 4,
  parameter int GROUP_W   = 5
) (
  input  logic [NUM_HARTS-1:0]              rise_i,
  input  logic [NUM_HARTS-1:0]              halted_i,
  input  logic [NUM_HARTS-1:0]              avail_i,
  input  logic [NUM_HARTS-1:0][GROUP_W-1:0] group_i,
  output logic [NUM_HARTS-1:0]              grp_halt_o
);

  for (genvar j = 0; j < NUM_HARTS; j++) begin : g_tgt
    logic hit;
    always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NUM_HARTS; i++) begin
        if (i != j && rise_i[i] && (group_i[i] != '0) && (group_i[i] == group_i[j]))
          hit = 1'b1;
      end
      grp_halt_o[j] = hit & avail_i[j] & ~halted_i[j];
    end
  end

endmodule

// File: rtl/dbg_status_agg.sv
module dbg_status_agg
  import dbg_avail_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int SEL_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [NUM_HARTS-1:0] halted_i,
  input  logic [NUM_HARTS-1:0] avail_i,
  input  logic [NUM_HARTS-1:0] resumeack_i,
  input  logic [NUM_HARTS-1:0] havereset_i,
  output status_t              st_o
);

  localparam logic [SEL_W:0] HART_CNT = (SEL_W+1)'(NUM_HARTS);

  always_comb begin
    st_o              = '0;
    st_o.allhalted    = 1'b1;
    st_o.allrunning   = 1'b1;
    st_o.allunavail   = 1'b1;
    st_o.allnonexist  = 1'b1;
    st_o.allresumeack = 1'b1;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (sel_i == SEL_W'(i)) begin
        st_o.allnonexist = 1'b0;
        st_o.havereset   = havereset_i[i];
        if (resumeack_i[i]) st_o.anyresumeack = 1'b1;
        else                st_o.allresumeack = 1'b0;
        if (halted_i[i]) begin
          st_o.anyhalted  = 1'b1;
          st_o.allrunning = 1'b0;
          st_o.allunavail = 1'b0;
        end else if (!avail_i[i]) begin
          st_o.allrunning = 1'b0;
          st_o.allhalted  = 1'b0;
          st_o.anyunavail = 1'b1;
        end else begin
          st_o.anyrunning = 1'b1;
          st_o.allhalted  = 1'b0;
          st_o.allunavail = 1'b0;
        end
      end
    end
    st_o.anynonexist = ({1'b0, sel_i} >= HART_CNT);
  end

  // R3
  one_category_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({st_o.anyhalted, st_o.anyrunning, st_o.anyunavail}) <= 1);

  // R4
  nonexist_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_o.anynonexist |-> (st_o.allunavail && !st_o.anyunavail && st_o.allhalted && st_o.allnonexist));

endmodule

// File: rtl/dbg_avail_ctrl.sv
module dbg_avail_ctrl
  import dbg_avail_pkg::*;
#(
  parameter int NUM_HARTS = 4,
  parameter int AVAIL_W   = 2,
  parameter int SEL_W     = 4,
  parameter int GROUP_W   = 5,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_req_i,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [DATA_W-1:0]    reg_wdata_i,
  output logic [DATA_W-1:0]    reg_rdata_o,
  output logic                 reg_rvalid_o,
  input  logic [NUM_HARTS-1:0] hart_halted_i,
  output logic [NUM_HARTS-1:0] halt_req_o,
  output logic [NUM_HARTS-1:0] halt_grp_o,
  output logic [NUM_HARTS-1:0] resume_o,
  output logic [NUM_HARTS-1:0] hart_reset_o
);

  localparam int STAT_PAD  = DATA_W - STATUS_W;
  localparam int AVAIL_PAD = DATA_W - AVAIL_W;
  localparam int GROUP_PAD = DATA_W - GROUP_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  logic rst_int_n;
  assign rst_int_n = rst_sync_q;

  // register port decode
  logic wr_en, rd_en, ctl_wr, avail_wr, grp_wr;
  logic [SEL_W-1:0] wr_sel;
  assign wr_en    = reg_req_i & reg_we_i;
  assign rd_en    = reg_req_i & ~reg_we_i;
  assign ctl_wr   = wr_en & (reg_addr_i == ADDR_W'(ADDR_CTRL));
  assign avail_wr = wr_en & (reg_addr_i == ADDR_W'(ADDR_AVAIL));
  assign grp_wr   = wr_en & (reg_addr_i == ADDR_W'(ADDR_GROUP));
  assign wr_sel   = reg_wdata_i[CTL_SEL_LSB +: SEL_W];

  logic [SEL_W-1:0]   sel_q;
  logic [AVAIL_W-1:0] avail_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q   <= '0;
      avail_q <= '1;
    end else begin
      if (ctl_wr)   sel_q   <= wr_sel;
      if (avail_wr) avail_q <= reg_wdata_i[AVAIL_W-1:0];
    end
  end

  // per-hart availability, harts beyond the register range stay available
  logic [NUM_HARTS-1:0] avail_vec;
  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_avail
    if (i < AVAIL_W) begin : g_reg
      assign avail_vec[i] = avail_q[i];
    end else begin : g_fixed
      assign avail_vec[i] = 1'b1;
    end
  end

  logic [NUM_HARTS-1:0]              rise_vec, grp_halt_vec, resack_vec, havereset_vec;
  logic [NUM_HARTS-1:0][GROUP_W-1:0] group_vec;

  for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
    logic ctl_hit, grp_hit;
    assign ctl_hit = ctl_wr & (wr_sel == SEL_W'(i));
    assign grp_hit = grp_wr & (sel_q == SEL_W'(i));
    dbg_hart_slot #(.GROUP_W(GROUP_W)) u_slot (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .ctl_wr_i      (ctl_hit),
      .haltreq_i     (reg_wdata_i[CTL_HALT_BIT]),
      .resumereq_i   (reg_wdata_i[CTL_RESUME_BIT]),
      .hartreset_i   (reg_wdata_i[CTL_HRESET_BIT]),
      .ackhr_i       (reg_wdata_i[CTL_ACKHR_BIT]),
      .grp_wr_i      (grp_hit),
      .grp_wdata_i   (reg_wdata_i[GROUP_W-1:0]),
      .avail_i       (avail_vec[i]),
      .halted_i      (hart_halted_i[i]),
      .grp_halt_i    (grp_halt_vec[i]),
      .halted_rise_o (rise_vec[i]),
      .group_o       (group_vec[i]),
      .resumeack_o   (resack_vec[i]),
      .havereset_o   (havereset_vec[i]),
      .halt_req_o    (halt_req_o[i]),
      .halt_grp_o    (halt_grp_o[i]),
      .resume_o      (resume_o[i]),
      .reset_o       (hart_reset_o[i])
    );
  end

  dbg_group_fanout #(.NUM_HARTS(NUM_HARTS), .GROUP_W(GROUP_W)) u_fanout (
    .rise_i     (rise_vec),
    .halted_i   (hart_halted_i),
    .avail_i    (avail_vec),
    .group_i    (group_vec),
    .grp_halt_o (grp_halt_vec)
  );

  status_t st;
  dbg_status_agg #(.NUM_HARTS(NUM_HARTS), .SEL_W(SEL_W)) u_status (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sel_i       (sel_q),
    .halted_i    (hart_halted_i),
    .avail_i     (avail_vec),
    .resumeack_i (resack_vec),
    .havereset_i (havereset_vec),
    .st_o        (st)
  );

  // read path
  logic [GROUP_W-1:0] sel_group;
  logic [DATA_W-1:0]  rd_word;
  logic [DATA_W-1:0]  rdata_q;
  logic               rvalid_q;

  always_comb begin
    sel_group = '0;
    for (int i = 0; i < NUM_HARTS; i++) begin
      if (sel_q == SEL_W'(i)) sel_group = group_vec[i];
    end
  end

  always_comb begin
    rd_word = '0;
    if (reg_addr_i == ADDR_W'(ADDR_STAT))       rd_word = {{STAT_PAD{1'b0}}, st};
    else if (reg_addr_i == ADDR_W'(ADDR_AVAIL)) rd_word = {{AVAIL_PAD{1'b0}}, avail_q};
    else if (reg_addr_i == ADDR_W'(ADDR_GROUP)) rd_word = {{GROUP_PAD{1'b0}}, sel_group};
    else if (reg_addr_i == ADDR_W'(ADDR_CTRL))  rd_word[CTL_SEL_LSB +: SEL_W] = sel_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign reg_rdata_o  = rdata_q;
  assign reg_rvalid_o = rvalid_q;

  // R11
  rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    reg_rvalid_o |-> $past(reg_req_i && !reg_we_i));

  // R1
  avail_write_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$stable(avail_q) |-> $past(avail_wr));

endmodule

// File: tb/dbg_avail_ctrl_tb.sv
`timescale 1ns/1ps
module dbg_avail_ctrl_tb_top;

  localparam int N = 4;
  localparam logic [6:0] A_CTRL = 7'h10, A_STAT = 7'h11, A_AVAIL = 7'h1F, A_GROUP = 7'h32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [N-1:0] halted = '0;
  logic [N-1:0] hreq, hgrp, res, hrst;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  dbg_avail_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .reg_rvalid_o(rvalid),
    .hart_halted_i(halted), .halt_req_o(hreq), .halt_grp_o(hgrp),
    .resume_o(res), .hart_reset_o(hrst)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ctl(input int sel, input bit h, input bit r, input bit hr, input bit ack);
    logic [31:0] v;
    v = '0;
    v[31] = h; v[30] = r; v[29] = hr; v[28] = ack;
    v[19:16] = 4'(sel);
    return v;
  endfunction

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    check({31'b0, rvalid}, 32'd1, "R11 rvalid");
    d = rdata;
  endtask

  // expected status bits [7:0] from the field rules
  function automatic logic [7:0] exp_stat(input int s, input bit hv, input logic [1:0] m);
    bit anyh, allh, anyr, allr, anyu, allu, anyn, alln, av;
    anyh = 0; allh = 1; anyr = 0; allr = 1; anyu = 0; allu = 1; alln = 1;
    anyn = (s >= N);
    if (s < N) begin
      alln = 0;
      av = (s >= 2) ? 1'b1 : m[s];
      if (hv) begin anyh = 1; allr = 0; allu = 0; end
      else if (!av) begin allr = 0; allh = 0; anyu = 1; end
      else begin anyr = 1; allh = 0; allu = 0; end
    end
    return {alln, anyn, allu, anyu, allr, anyr, allh, anyh};
  endfunction

  initial begin
    #(4ns * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    rd(A_AVAIL, d);
    check(d, 32'h3, "R1 reset avail");
    rd(A_STAT, d);
    check(d, 32'h40C, "R3 reset status");
    check({28'b0, hreq}, 32'h0, "R5 reset halt_req");
    rd(7'h05, d);
    check(d, 32'h0, "R11 unmapped read");

    // status sweep: mask x select x halted
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 6; s++) begin
        for (int hv = 0; hv < 2; hv++) begin
          halted = hv[0] ? 4'hF : 4'h0;
          wr(A_AVAIL, 32'(m));
          wr(A_CTRL, ctl(s, 0, 0, 0, 0));
          rd(A_STAT, d);
          if (s >= N) check({24'b0, d[7:0]}, {24'b0, exp_stat(s, hv[0], 2'(m))}, "R4 nonexistent status");
          else        check({24'b0, d[7:0]}, {24'b0, exp_stat(s, hv[0], 2'(m))}, "R3 status");
        end
      end
    end
    halted = '0;
    repeat (2) @(negedge clk);

    // availability register ignores upper bits
    wr(A_AVAIL, 32'hFFFF_FFFC);
    rd(A_AVAIL, d);
    check(d, 32'h0, "R1 upper bits ignored");

    // halt gating sweep
    for (int m = 0; m < 4; m++) begin
      for (int h = 0; h < N; h++) begin
        bit av;
        av = (h >= 2) ? 1'b1 : m[h];
        wr(A_AVAIL, 32'(m));
        wr(A_CTRL, ctl(h, 1, 0, 0, 0));
        if (h >= 2) check({31'b0, hreq[h]}, {31'b0, av}, "R2 beyond-range hart halts");
        else        check({31'b0, hreq[h]}, {31'b0, av}, "R5 halt gated");
        check({31'b0, hgrp[h]}, 32'h0, "R5 regular kind");
        repeat (3) @(negedge clk);
        check({31'b0, hreq[h]}, {31'b0, av}, "R5 level held");
        wr(A_CTRL, ctl(h, 0, 0, 0, 0));
        check({31'b0, hreq[h]}, 32'h0, "R5 cleared");
      end
    end

    // resume
    wr(A_AVAIL, 32'h3);
    halted = 4'b0001;
    repeat (2) @(negedge clk);
    wr(A_CTRL, ctl(0, 0, 1, 0, 0));
    check({28'b0, res}, 32'h1, "R6 resume pulse");
    @(negedge clk);
    check({28'b0, res}, 32'h0, "R6 pulse one cycle");
    rd(A_STAT, d);
    check({31'b0, d[8]}, 32'h0, "R6 resumeack cleared");
    halted = 4'b0000;
    @(negedge clk);
    rd(A_STAT, d);
    check({31'b0, d[8]}, 32'h1, "R6 resumeack on fall");
    wr(A_AVAIL, 32'h2);
    halted = 4'b0001;
    repeat (2) @(negedge clk);
    wr(A_CTRL, ctl(0, 0, 1, 0, 0));
    check({28'b0, res}, 32'h0, "R6 resume gated");
    rd(A_STAT, d);
    check({31'b0, d[8]}, 32'h1, "R6 resumeack kept");
    halted = 4'b0000;
    repeat (2) @(negedge clk);

    // hart reset / havereset
    wr(A_CTRL, ctl(0, 0, 0, 0, 1));
    rd(A_STAT, d);
    check({31'b0, d[10]}, 32'h0, "R7 ack while unavailable");
    wr(A_CTRL, ctl(0, 0, 0, 1, 0));
    check({28'b0, hrst}, 32'h0, "R7 reset gated");
    rd(A_STAT, d);
    check({31'b0, d[10]}, 32'h0, "R7 havereset unchanged");
    wr(A_AVAIL, 32'h3);
    wr(A_CTRL, ctl(0, 0, 0, 1, 0));
    check({28'b0, hrst}, 32'h1, "R7 reset pulse");
    rd(A_STAT, d);
    check({31'b0, d[10]}, 32'h1, "R7 havereset set");

    // groups: harts 0,1,2 in group 3, hart 3 in group 0, hart 1 unavailable
    for (int h = 0; h < 3; h++) begin
      wr(A_CTRL, ctl(h, 0, 0, 0, 0));
      wr(A_GROUP, 32'hFFFF_FFE3);
    end
    wr(A_CTRL, ctl(3, 0, 0, 0, 0));
    rd(A_GROUP, d);
    check(d, 32'h0, "R8 group reset value");
    wr(A_CTRL, ctl(2, 0, 0, 0, 0));
    rd(A_GROUP, d);
    check(d, 32'h3, "R8 group readback");
    wr(A_AVAIL, 32'h1);
    @(negedge clk);
    halted = 4'b0001;
    @(negedge clk);
    check({28'b0, hreq}, 32'h4, "R9 group fanout req");
    check({28'b0, hgrp}, 32'h4, "R9 group kind");

    // same-cycle: control write to hart 2 with group trigger
    wr(A_CTRL, ctl(2, 0, 0, 0, 0));
    halted = 4'b0000;
    repeat (2) @(negedge clk);
    @(negedge clk);
    halted = 4'b0001;
    req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = ctl(2, 0, 0, 0, 0);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check({31'b0, hreq[2]}, 32'h0, "R10 write wins on same hart");
    halted = 4'b0000;
    repeat (2) @(negedge clk);
    halted = 4'b0001;
    req = 1'b1; we = 1'b1; addr = A_CTRL; wdata = ctl(3, 0, 0, 0, 0);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    check({31'b0, hgrp[2]}, 32'h1, "R10 other hart still grouped");
    check({31'b0, hreq[3]}, 32'h0, "R9 outside group untouched");

    // zero group never spreads
    wr(A_CTRL, ctl(2, 0, 0, 0, 0));
    halted = 4'b0000;
    repeat (2) @(negedge clk);
    halted = 4'b1000;
    repeat (2) @(negedge clk);
    check({28'b0, hreq}, 32'h0, "R9 group zero no fanout");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule